// File: doc/BRIEF.md
# 64-bit Interval Timer with Split-Word Register Access

The block is a programmable interval timer. It has a counter two bus words wide and a compare period of the same width, both reached over a plain register bus one word wide. The counter advances on prescaled ticks. A tick comes either from every cycle of the bus clock or from pulses on a synchronous alternate tick-enable input. The divider takes a 4-bit value p and divides by p+1, so the ratio runs from 1 to 16. When a period elapses, the counter returns to zero and a pending flag is raised. In continuous mode the timer keeps running. In one-shot mode it halts after the first elapse. The interrupt line is the pending flag gated by its enable.

Software first issues a soft reset. It then writes the configuration, the period high word, the period low word and the interrupt enable, and last writes start. To read the counter, software reads the low word first. That read captures the high half, and the following high-word read returns the captured value, so the two reads form one coherent value even across a carry. Register offsets (byte addresses) are: control 0x00, configuration 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, counter low 0x20, counter high 0x24. The word width is a parameter (default 32), and the field positions below require at least 12 bits.

Top module: `ivt_timer`

## Requirements
- R1: After reset every readable register reads zero, the timer is stopped and `irq` is low.
- R2: Writing control bit 0 starts the timer. While it runs on the bus clock with prescale value p (configuration bits 11:8), the counter rises by one every p+1 cycles. While the timer is stopped, the counter does not change. Control reads return the running state in bit 0.
- R3: With configuration bit 3 set, the prescaler counts `alt_tick` pulses instead of bus-clock cycles, so the counter rises once per p+1 pulses and holds when there are none.
- R4: A tick that would bring the counter up to the programmed period instead returns the counter to zero and sets status bit 0. A period of N therefore elapses every N ticks, and a period of zero elapses once per full counter wrap.
- R5: With configuration bit 0 set, the timer keeps running after an elapse. With bit 0 clear it stops and clears the running state, the counter stays at zero, and a later start resumes counting from zero.
- R6: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both set.
- R7: A status read returns the pending flags and clears them. If an elapse happens in the same cycle as that read, the read returns the old value and the flag stays set.
- R8: A read of the counter low word returns the current low half and captures the high half. A read of the counter high word returns the captured half, even if the counter has carried in between.
- R9: Writing control bit 8 is a soft reset. It clears the counter, the prescaler phase, the running state, the configuration, the interrupt enable and the status, and it keeps the period registers. When bits 0 and 8 are written together, the soft reset wins and the timer stays stopped.
- R10: Configuration, both period words and the interrupt enable read back what was written, with unused bits reading zero. Writes to status and counter addresses have no effect.
- R11: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_tick | input | 1 | Alternate counting source, one pulse per tick |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WORD_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WORD_W | Registered read data |
| irq | output | 1 | Level interrupt for an elapsed period |

## Verification
The hardest case to reach from the ports is a low-then-high counter read that straddles a carry from the low half into the high half, because with bus-clock counting the low half only overflows after an enormous number of cycles. The bench instead builds the block with 16-bit words and counts on the alternate tick. It holds that input high for exactly 65535 cycles, which parks the counter at 0xFFFF. It then reads the low word, sends a single extra pulse, and reads the high word. The same precise control over the alternate tick lets the bench place an elapse in the very cycle of a status read.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_CFG    = 'h04;
  localparam int OFF_PER_LO = 'h08;
  localparam int OFF_PER_HI = 'h0C;
  localparam int OFF_IEN    = 'h10;
  localparam int OFF_STAT   = 'h1C;
  localparam int OFF_CNT_LO = 'h20;
  localparam int OFF_CNT_HI = 'h24;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_SRST_BIT = 8;
  localparam int CFG_CONT_BIT  = 0;
  localparam int CFG_ALT_BIT   = 3;
  localparam int CFG_DIV_LSB   = 8;
  localparam int DIV_W         = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             alt;
    logic             cont;
  } cfg_t;

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              elapse,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  period,
  output logic              ien,
  output logic              stat,
  output logic              go_req,
  output logic              srst_req
);

  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] rd_val;
  logic              hit_ctrl, hit_cfg, hit_plo, hit_phi, hit_ien;
  logic              hit_stat, hit_clo, hit_chi;

  assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
  assign hit_cfg  = bus_addr == ADDR_W'(OFF_CFG);
  assign hit_plo  = bus_addr == ADDR_W'(OFF_PER_LO);
  assign hit_phi  = bus_addr == ADDR_W'(OFF_PER_HI);
  assign hit_ien  = bus_addr == ADDR_W'(OFF_IEN);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
  assign hit_clo  = bus_addr == ADDR_W'(OFF_CNT_LO);
  assign hit_chi  = bus_addr == ADDR_W'(OFF_CNT_HI);

  // Soft reset outranks start when both bits arrive together
  assign srst_req = bus_wr && hit_ctrl && bus_wdata[CTRL_SRST_BIT];
  assign go_req   = bus_wr && hit_ctrl && bus_wdata[CTRL_GO_BIT] && !bus_wdata[CTRL_SRST_BIT];

  // Configuration and enable: cleared by soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      ien <= 1'b0;
    end else if (srst_req) begin
      cfg <= '0;
      ien <= 1'b0;
    end else if (bus_wr) begin
      if (hit_cfg) begin
        cfg.cont <= bus_wdata[CFG_CONT_BIT];
        cfg.alt  <= bus_wdata[CFG_ALT_BIT];
        cfg.div  <= bus_wdata[CFG_DIV_LSB +: DIV_W];
      end
      if (hit_ien) ien <= bus_wdata[0];
    end
  end

  // Period words survive soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
    end else if (bus_wr) begin
      if (hit_plo) period[WORD_W-1:0]     <= bus_wdata;
      if (hit_phi) period[CNT_W-1:WORD_W] <= bus_wdata;
    end
  end

  // Pending flag: new elapse beats the read-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stat <= 1'b0;
    else if (srst_req)           stat <= 1'b0;
    else if (elapse)             stat <= 1'b1;
    else if (bus_rd && hit_stat) stat <= 1'b0;
  end

  // High half captured by a low-word read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 shadow_q <= '0;
    else if (bus_rd && hit_clo) shadow_q <= cnt[CNT_W-1:WORD_W];
  end

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      hit_ctrl: rd_val[CTRL_GO_BIT] = running;
      hit_cfg: begin
        rd_val[CFG_CONT_BIT]             = cfg.cont;
        rd_val[CFG_ALT_BIT]              = cfg.alt;
        rd_val[CFG_DIV_LSB +: DIV_W]     = cfg.div;
      end
      hit_plo:  rd_val = period[WORD_W-1:0];
      hit_phi:  rd_val = period[CNT_W-1:WORD_W];
      hit_ien:  rd_val[0] = ien;
      hit_stat: rd_val[0] = stat;
      hit_clo:  rd_val = cnt[WORD_W-1:0];
      hit_chi:  rd_val = shadow_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/ivt_prescale.sv
module ivt_prescale
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_alt,
  input  logic             alt_tick,
  input  logic [DIV_W-1:0] div,
  input  logic             srst,
  output logic             tick
);

  logic [DIV_W-1:0] phase_q;
  logic             src;

  assign src  = use_alt ? alt_tick : 1'b1;
  assign tick = run && src && (phase_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (srst)       phase_q <= '0;
    else if (run && src) phase_q <= (phase_q == div) ? '0 : phase_q + 1'b1;
  end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic             cont,
  input  logic             go,
  input  logic             srst,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             elapse
);

  logic [CNT_W-1:0] nxt;

  assign nxt    = cnt + 1'b1;
  assign elapse = tick && (nxt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (srst)   cnt <= '0;
    else if (elapse) cnt <= '0;
    else if (tick)   cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 running <= 1'b0;
    else if (srst)              running <= 1'b0;
    else if (go)                running <= 1'b1;
    else if (elapse && !cont)   running <= 1'b0;
  end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * WORD_W;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ien_q, stat_q, run_q, elapse_w;
  logic             go_w, srst_w, tick_w, cont_w;

  assign cont_w = cfg_q.cont;

  ivt_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt(cnt_q), .running(run_q), .elapse(elapse_w),
    .cfg(cfg_q), .period(period_q), .ien(ien_q), .stat(stat_q),
    .go_req(go_w), .srst_req(srst_w)
  );

  ivt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .use_alt(cfg_q.alt),
    .alt_tick(alt_tick), .div(cfg_q.div), .srst(srst_w), .tick(tick_w)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .period(period_q),
    .cont(cont_w), .go(go_w), .srst(srst_w),
    .cnt(cnt_q), .running(run_q), .elapse(elapse_w)
  );

  assign irq = stat_q && ien_q;

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             srst,
  input logic             go,
  input logic             running,
  input logic             cont,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             stat,
  input logic             ien,
  input logic             irq
);

  logic [CNT_W-1:0] nxt;
  assign nxt = cnt + 1'b1;

  p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> running);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !srst) |=> cnt == $past(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && nxt != period) |=> cnt == $past(nxt));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && nxt == period) |=> (cnt == '0 && stat));

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && !go && !cont && nxt == period) |=> !running);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  p_srst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cnt == '0 && !running && !stat && !ien && !irq));

endmodule

bind ivt_timer ivt_checker #(.CNT_W(2 * WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .srst(srst_w), .go(go_w),
  .running(run_q), .cont(cont_w), .cnt(cnt_q), .period(period_q),
  .stat(stat_q), .ien(ien_q), .irq(irq)
);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;

  localparam int W = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_PLO = 8'h08,
                         A_PHI = 8'h0C, A_IEN = 8'h10, A_STAT = 8'h1C,
                         A_CLO = 8'h20, A_CHI = 8'h24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         alt_tick = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_rdata;
  logic         irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W-1:0] q_val[$];
  string        q_tag[$];
  logic         rd_due = 1'b0;

  always #5 clk = ~clk;

  ivt_timer #(.WORD_W(W), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: one expected item per read strobe, compared after the edge
  always @(posedge clk) rd_due <= bus_rd;

  always @(negedge clk) begin
    if (rd_due) begin
      logic [W-1:0] e;
      string        t;
      total++;
      if (q_val.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        e = q_val.pop_front();
        t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    q_val.push_back(e); q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    alt_tick = 1'b1;
    repeat (n) @(negedge clk);
    alt_tick = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk({{(W-1){1'b0}}, irq}, '0, "R1 irq");
    rd(A_CTRL, 16'h0000, "R1 ctrl");
    rd(A_CFG,  16'h0000, "R1 cfg");
    rd(A_STAT, 16'h0000, "R1 stat");
    rd(A_CLO,  16'h0000, "R1 cnt_lo");
    rd(A_PLO,  16'h0000, "R1 per_lo");

    // R10: readback and ignored writes
    wr(A_CFG, 16'hF30D);
    rd(A_CFG, 16'h0309, "R10 cfg");
    wr(A_PLO, 16'h1234);
    wr(A_PHI, 16'hABCD);
    rd(A_PLO, 16'h1234, "R10 per_lo");
    rd(A_PHI, 16'hABCD, "R10 per_hi");
    wr(A_IEN, 16'hFFFF);
    rd(A_IEN, 16'h0001, "R10 ien");
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, 16'h0000, "R10 stat write ignored");
    chk({{(W-1){1'b0}}, irq}, '0, "R10 irq after stat write");
    wr(A_CLO, 16'h0055);
    rd(A_CLO, 16'h0000, "R10 cnt write ignored");

    // R9: soft reset keeps period, clears the rest
    wr(A_CTRL, 16'h0100);
    rd(A_CFG, 16'h0000, "R9 cfg cleared");
    rd(A_IEN, 16'h0000, "R9 ien cleared");
    rd(A_PLO, 16'h1234, "R9 period kept");

    // R4/R6/R7: continuous, divide by 4, period 2 -> elapse every 8 cycles
    wr(A_CFG, 16'h0301);
    wr(A_PHI, 16'h0000);
    wr(A_PLO, 16'h0002);
    wr(A_IEN, 16'h0001);
    wr(A_CTRL, 16'h0001);
    repeat (7) @(negedge clk);
    chk({{(W-1){1'b0}}, irq}, '0, "R4 irq before elapse");
    @(negedge clk);
    chk({{(W-1){1'b0}}, irq}, 16'h0001, "R6 irq at elapse");
    rd(A_STAT, 16'h0001, "R7 stat pending");
    chk({{(W-1){1'b0}}, irq}, '0, "R7 irq cleared by read");
    rd(A_CTRL, 16'h0001, "R5 continuous still running");

    // R2: count rate on bus clock
    wr(A_CTRL, 16'h0100);
    wr(A_CFG, 16'h0001);
    wr(A_PHI, 16'h0001);
    wr(A_CTRL, 16'h0001);
    repeat (8) @(negedge clk);
    rd(A_CLO, 16'd9, "R2 divide by 1");
    wr(A_CTRL, 16'h0100);
    wr(A_CFG, 16'h0301);
    wr(A_CTRL, 16'h0001);
    repeat (19) @(negedge clk);
    rd(A_CLO, 16'd5, "R2 divide by 4");

    // R5: one-shot with period 3
    wr(A_CTRL, 16'h0100);
    wr(A_CFG, 16'h0000);
    wr(A_PHI, 16'h0000);
    wr(A_PLO, 16'h0003);
    wr(A_CTRL, 16'h0001);
    repeat (10) @(negedge clk);
    rd(A_CTRL, 16'h0000, "R5 one-shot stopped");
    rd(A_CLO, 16'h0000, "R5 counter at zero");
    rd(A_STAT, 16'h0001, "R4 one-shot flag");
    wr(A_CTRL, 16'h0001);
    rd(A_CLO, 16'h0001, "R5 restart from zero");

    // R3: alternate source, divide by 3
    wr(A_CTRL, 16'h0100);
    wr(A_CFG, 16'h0209);
    wr(A_PHI, 16'h0001);
    wr(A_CTRL, 16'h0001);
    repeat (10) @(negedge clk);
    rd(A_CLO, 16'h0000, "R3 no pulses no count");
    pulse(7);
    rd(A_CLO, 16'h0002, "R3 seven pulses");

    // R7: elapse in the same cycle as a status read
    wr(A_CTRL, 16'h0100);
    wr(A_CFG, 16'h0009);
    wr(A_PHI, 16'h0000);
    wr(A_PLO, 16'h0001);
    wr(A_IEN, 16'h0001);
    wr(A_CTRL, 16'h0001);
    rd(A_STAT, 16'h0000, "R7 nothing pending");
    @(negedge clk);
    alt_tick = 1'b1; bus_addr = A_STAT; bus_rd = 1'b1;
    q_val.push_back(16'h0000); q_tag.push_back("R7 read in elapse cycle");
    @(negedge clk);
    alt_tick = 1'b0; bus_rd = 1'b0;
    chk({{(W-1){1'b0}}, irq}, 16'h0001, "R7 flag survived read");
    rd(A_STAT, 16'h0001, "R7 flag kept");
    rd(A_STAT, 16'h0000, "R7 flag now clear");

    // R9: soft reset with pending interrupt, then priority over start
    pulse(1);
    chk({{(W-1){1'b0}}, irq}, 16'h0001, "R6 irq pending");
    wr(A_CTRL, 16'h0100);
    chk({{(W-1){1'b0}}, irq}, '0, "R9 irq dropped");
    rd(A_STAT, 16'h0000, "R9 stat cleared");
    rd(A_PLO, 16'h0001, "R9 period kept");
    wr(A_CTRL, 16'h0101);
    repeat (4) @(negedge clk);
    rd(A_CTRL, 16'h0000, "R9 reset beats start");
    rd(A_CLO, 16'h0000, "R9 counter idle");

    // R11: read data holds between strobes
    rd(A_PLO, 16'h0001, "R11 read");
    repeat (3) @(negedge clk);
    chk(bus_rdata, 16'h0001, "R11 data held");

    // R8: coherent read across low-half carry
    wr(A_CFG, 16'h0009);
    wr(A_PLO, 16'h0000);
    wr(A_PHI, 16'h0000);
    wr(A_CTRL, 16'h0001);
    pulse(65535);
    rd(A_CLO, 16'hFFFF, "R8 low before carry");
    pulse(1);
    rd(A_CHI, 16'h0000, "R8 high from capture");
    rd(A_CLO, 16'h0000, "R8 low after carry");
    rd(A_CHI, 16'h0001, "R8 high after carry");

    repeat (3) @(negedge clk);
    if (q_val.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q_val.size());
    end
    finish_up();
  end

endmodule